// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the purely combinational arithmetic and logic stage of a small 8-bit accumulator processor. Each operation takes an operation code, a register value (the accumulator, an index register, or a memory byte that the caller routes onto the register input for read-modify-write forms), a memory operand and the current carry. From these it produces a result and new negative (N), zero (Z), carry (C) and overflow (V) flags.

Each flag has its own write enable. The result has a write enable too. The surrounding datapath latches a flag or the result only when its enable is high, so anything an operation does not define keeps its old value. When the result enable is low, the result output simply repeats the register input. Decimal arithmetic is not provided. Storage of registers and flags, and any memory writeback, sit outside the block.

The data width is a parameter with a default of 8. All values below assume that default.

Top module: `acc_alu`

## Requirements
- R1: Add (op 4'h0) returns the low 8 bits of reg + mem + carry_in, sets C when that sum exceeds 255, and writes the result and all four flags.
- R2: For add, V is set exactly when reg and mem have the same sign bit and the result's sign bit differs from it, i.e. when the signed sum leaves the range -128..127.
- R3: Subtract (op 4'h1) adds the inverted mem plus carry_in, so the result is reg - mem - (1 - carry_in). C = 1 means no borrow. V is set when the signed difference leaves -128..127. It writes the result and all four flags.
- R4: OR (op 4'h2), AND (op 4'h3) and XOR (op 4'h4) write the bitwise result and update only N and Z.
- R5: Compare (op 4'h5) sets C when reg >= mem (unsigned), Z when they are equal, and N from bit 7 of reg - mem. It does not enable V and does not enable the result write.
- R6: Increment (op 4'h6) and decrement (op 4'h7) act on reg, wrap modulo 256, write the result and update only N and Z.
- R7: Shift left (op 4'h8) moves reg bit 7 into C and shifts in 0. Logical shift right (op 4'h9) moves reg bit 0 into C and shifts in 0. Both write the result and update N, Z and C.
- R8: Rotate left (op 4'hA) feeds carry_in into bit 0 and reg bit 7 into C. Rotate right (op 4'hB) feeds carry_in into bit 7 and reg bit 0 into C. Both write the result and update N, Z and C.
- R9: Bit test (op 4'hC) sets Z when (reg AND mem) is zero, and copies mem bit 7 to N and mem bit 6 to V. It enables N, Z and V, leaves C disabled, and does not write the result.
- R10: Load/transfer (op 4'hD) writes mem as the result and updates only N and Z.
- R11: Transfer to the stack pointer (op 4'hE) writes mem as the result with every flag enable low.
- R12: Hold (op 4'hF) enables nothing. Whenever the result enable is low, result_o equals reg_i.
- R13: For every flag-updating operation other than bit test, N is bit 7 of the result and Z is set when the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| reg_i | input | 8 | Register or read-modify-write operand |
| mem_i | input | 8 | Memory operand |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 8 | Operation result |
| result_we_o | output | 1 | Result write enable |
| n_o | output | 1 | New negative flag |
| z_o | output | 1 | New zero flag |
| c_o | output | 1 | New carry flag |
| v_o | output | 1 | New overflow flag |
| n_we_o | output | 1 | Negative flag write enable |
| z_we_o | output | 1 | Zero flag write enable |
| c_we_o | output | 1 | Carry flag write enable |
| v_we_o | output | 1 | Overflow flag write enable |

## Verification
Carry-out and signed overflow come from the same addition in one evaluation, and either can occur without the other. The bench sweeps add and subtract over many operand and carry combinations, including 0x80+0x80, where both flags rise together and Z also rises. It checks each flag against its own rule: C from the unsigned total and V from the signed range, both computed in integer arithmetic rather than from sign bits. Compare uses the same adder, so it is checked alongside to confirm that C and Z are produced there while the overflow and result enables stay low.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] reg_i,
  input  logic [W-1:0] mem_i,
  input  logic         carry_i,
  output logic [W-1:0] result_o,
  output logic         result_we_o,
  output logic         n_o,
  output logic         z_o,
  output logic         c_o,
  output logic         v_o,
  output logic         n_we_o,
  output logic         z_we_o,
  output logic         c_we_o,
  output logic         v_we_o
);
  localparam int MSB = W - 1;
  localparam logic [3:0] OP_ADD = 4'h0, OP_SUB = 4'h1, OP_OR  = 4'h2, OP_AND = 4'h3,
                         OP_XOR = 4'h4, OP_CMP = 4'h5, OP_INC = 4'h6, OP_DEC = 4'h7,
                         OP_ASL = 4'h8, OP_LSR = 4'h9, OP_ROL = 4'hA, OP_ROR = 4'hB,
                         OP_BIT = 4'hC, OP_MOV = 4'hD, OP_MSP = 4'hE;

  logic         invert, cin, ovf;
  logic [W-1:0] addend, val;
  logic [W:0]   sum;
  logic         nz_we;

  assign invert = (op_i == OP_SUB) || (op_i == OP_CMP);
  assign addend = invert ? ~mem_i : mem_i;
  assign cin    = (op_i == OP_CMP) ? 1'b1 : carry_i;
  assign sum    = {1'b0, reg_i} + {1'b0, addend} + {{W{1'b0}}, cin};
  assign ovf    = ~(reg_i[MSB] ^ addend[MSB]) & (reg_i[MSB] ^ sum[MSB]);

  always_comb begin
    val         = reg_i;
    result_we_o = 1'b0;
    nz_we       = 1'b0;
    c_we_o      = 1'b0;
    v_we_o      = 1'b0;
    c_o         = 1'b0;
    v_o         = 1'b0;
    case (op_i)
      OP_ADD, OP_SUB: begin
        val = sum[MSB:0];
        c_o = sum[W];
        v_o = ovf;
        result_we_o = 1'b1; nz_we = 1'b1; c_we_o = 1'b1; v_we_o = 1'b1;
      end
      OP_OR:  begin val = reg_i | mem_i; result_we_o = 1'b1; nz_we = 1'b1; end
      OP_AND: begin val = reg_i & mem_i; result_we_o = 1'b1; nz_we = 1'b1; end
      OP_XOR: begin val = reg_i ^ mem_i; result_we_o = 1'b1; nz_we = 1'b1; end
      OP_CMP: begin
        val = sum[MSB:0];
        c_o = sum[W];
        nz_we = 1'b1; c_we_o = 1'b1;
      end
      OP_INC: begin val = reg_i + 1'b1; result_we_o = 1'b1; nz_we = 1'b1; end
      OP_DEC: begin val = reg_i - 1'b1; result_we_o = 1'b1; nz_we = 1'b1; end
      OP_ASL: begin
        {c_o, val} = {reg_i, 1'b0};
        result_we_o = 1'b1; nz_we = 1'b1; c_we_o = 1'b1;
      end
      OP_LSR: begin
        {val, c_o} = {1'b0, reg_i};
        result_we_o = 1'b1; nz_we = 1'b1; c_we_o = 1'b1;
      end
      OP_ROL: begin
        {c_o, val} = {reg_i, carry_i};
        result_we_o = 1'b1; nz_we = 1'b1; c_we_o = 1'b1;
      end
      OP_ROR: begin
        {val, c_o} = {carry_i, reg_i};
        result_we_o = 1'b1; nz_we = 1'b1; c_we_o = 1'b1;
      end
      OP_BIT: begin
        val = reg_i & mem_i;
        v_o = mem_i[MSB-1];
        nz_we = 1'b1; v_we_o = 1'b1;
      end
      OP_MOV: begin val = mem_i; result_we_o = 1'b1; nz_we = 1'b1; end
      OP_MSP: begin val = mem_i; result_we_o = 1'b1; end
      default: ;
    endcase
  end

  assign n_o      = (op_i == OP_BIT) ? mem_i[MSB] : val[MSB];
  assign z_o      = (val == '0);
  assign n_we_o   = nz_we;
  assign z_we_o   = nz_we;
  assign result_o = result_we_o ? val : reg_i;
endmodule

module acc_alu_props #(
  parameter int W = 8
) (
  input logic [3:0]   op_i,
  input logic [W-1:0] reg_i,
  input logic [W-1:0] mem_i,
  input logic         carry_i,
  input logic [W-1:0] result_o,
  input logic         result_we_o,
  input logic         n_o,
  input logic         z_o,
  input logic         c_o,
  input logic         v_o,
  input logic         n_we_o,
  input logic         z_we_o,
  input logic         c_we_o,
  input logic         v_we_o
);
  logic [W:0] wide_add;
  assign wide_add = {1'b0, reg_i} + {1'b0, mem_i} + {{W{1'b0}}, carry_i};

  always_comb begin
    if (op_i == 4'h0)
      p_add_total_r1: assert ({c_o, result_o} == wide_add);
    if (op_i == 4'h5) begin
      p_cmp_ge_carry_r5: assert (c_o == (reg_i >= mem_i));
      p_cmp_no_write_r5: assert (!v_we_o && !result_we_o && c_we_o && result_o == reg_i);
    end
    if (op_i == 4'h6)
      p_inc_wrap_r6: assert (result_o == W'(reg_i + 1'b1) && !c_we_o && !v_we_o);
    if (op_i == 4'hC)
      p_bit_copy_r9: assert (n_o == mem_i[W-1] && v_o == mem_i[W-2] && !c_we_o && !result_we_o);
    if (op_i == 4'hE)
      p_sp_quiet_r11: assert (!n_we_o && !z_we_o && !c_we_o && !v_we_o && result_o == mem_i);
    if (op_i == 4'hF)
      p_hold_idle_r12: assert (!result_we_o && !n_we_o && !c_we_o && !v_we_o && result_o == reg_i);
  end
endmodule

bind acc_alu acc_alu_props #(.W(W)) props_i (
  .op_i(op_i), .reg_i(reg_i), .mem_i(mem_i), .carry_i(carry_i),
  .result_o(result_o), .result_we_o(result_we_o),
  .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o),
  .n_we_o(n_we_o), .z_we_o(z_we_o), .c_we_o(c_we_o), .v_we_o(v_we_o)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [3:0] op;
  logic [7:0] rv, mv, res;
  logic       cy, rwe, n, z, c, v, nwe, zwe, cwe, vwe;
  int         checks = 0, fails = 0;
  bit         done = 0;

  acc_alu dut_i (
    .op_i(op), .reg_i(rv), .mem_i(mv), .carry_i(cy),
    .result_o(res), .result_we_o(rwe),
    .n_o(n), .z_o(z), .c_o(c), .v_o(v),
    .n_we_o(nwe), .z_we_o(zwe), .c_we_o(cwe), .v_we_o(vwe)
  );

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic apply(logic [3:0] o, logic [7:0] r, logic [7:0] m, logic ci);
    @(negedge clk);
    op = o; rv = r; mv = m; cy = ci;
    #1;
  endtask

  // enables ordered {result, n, z, c, v}; flag values compared only where enabled
  task automatic expect_out(string req, int eres, logic [4:0] ewe, logic [3:0] ef);
    chk(req, "result", res, eres);
    chk(req, "enables", {rwe, nwe, zwe, cwe, vwe}, ewe);
    if (ewe[3]) chk(req, "N", n, ef[3]);
    if (ewe[2]) chk(req, "Z", z, ef[2]);
    if (ewe[1]) chk(req, "C", c, ef[1]);
    if (ewe[0]) chk(req, "V", v, ef[0]);
  endtask

  function automatic int sgn(logic [7:0] x);
    return x[7] ? int'(x) - 256 : int'(x);
  endfunction

  task automatic t_reset;
    apply(4'hF, 8'h5A, 8'h33, 1'b1);
    expect_out("R12", 8'h5A, 5'b00000, 4'h0);
  endtask

  task automatic t_add;
    for (int i = 0; i < 40; i++) begin
      logic [7:0] r = 8'(i * 29 + 3);
      logic [7:0] m = 8'(i * 71 + 120);
      logic ci = i[0];
      int s = int'(r) + int'(m) + int'(ci);
      int ss = sgn(r) + sgn(m) + int'(ci);
      logic [7:0] e = 8'(s);
      apply(4'h0, r, m, ci);
      expect_out("R1/R2/R13", e, 5'b11111, {e[7], e == 0, s > 255, (ss > 127 || ss < -128)});
    end
    apply(4'h0, 8'h80, 8'h80, 1'b0);
    expect_out("R2", 8'h00, 5'b11111, 4'b0111);
    apply(4'h0, 8'h7F, 8'h00, 1'b1);
    expect_out("R2", 8'h80, 5'b11111, 4'b1001);
  endtask

  task automatic t_sub;
    for (int i = 0; i < 40; i++) begin
      logic [7:0] r = 8'(i * 53 + 7);
      logic [7:0] m = 8'(i * 37 + 200);
      logic ci = i[1];
      int s = int'(r) - int'(m) - (1 - int'(ci));
      int ss = sgn(r) - sgn(m) - (1 - int'(ci));
      logic [7:0] e = 8'(s);
      apply(4'h1, r, m, ci);
      expect_out("R3", e, 5'b11111, {e[7], e == 0, s >= 0, (ss > 127 || ss < -128)});
    end
    apply(4'h1, 8'h80, 8'h01, 1'b1);
    expect_out("R3", 8'h7F, 5'b11111, 4'b0011);
  endtask

  task automatic t_logic;
    apply(4'h2, 8'hF0, 8'h0F, 1'b0); expect_out("R4", 8'hFF, 5'b11100, 4'b1000);
    apply(4'h3, 8'hF0, 8'h0F, 1'b1); expect_out("R4", 8'h00, 5'b11100, 4'b0100);
    apply(4'h4, 8'hAA, 8'h3C, 1'b0); expect_out("R4", 8'h96, 5'b11100, 4'b1000);
  endtask

  task automatic t_cmp;
    for (int i = 0; i < 24; i++) begin
      logic [7:0] r = 8'(i * 45);
      logic [7:0] m = (i % 4 == 0) ? r : 8'(i * 97 + 11);
      logic [7:0] d = r - m;
      apply(4'h5, r, m, i[0]);
      expect_out("R5", r, 5'b01110, {d[7], r == m, r >= m, 1'b0});
    end
  endtask

  task automatic t_incdec;
    apply(4'h6, 8'hFF, 8'h00, 1'b0); expect_out("R6", 8'h00, 5'b11100, 4'b0100);
    apply(4'h6, 8'h7F, 8'h00, 1'b1); expect_out("R6", 8'h80, 5'b11100, 4'b1000);
    apply(4'h7, 8'h00, 8'h00, 1'b0); expect_out("R6", 8'hFF, 5'b11100, 4'b1000);
    apply(4'h7, 8'h01, 8'h00, 1'b1); expect_out("R6", 8'h00, 5'b11100, 4'b0100);
  endtask

  task automatic t_shift;
    apply(4'h8, 8'h81, 8'h00, 1'b1); expect_out("R7", 8'h02, 5'b11110, 4'b0010);
    apply(4'h8, 8'h40, 8'h00, 1'b0); expect_out("R7", 8'h80, 5'b11110, 4'b1000);
    apply(4'h9, 8'h01, 8'h00, 1'b1); expect_out("R7", 8'h00, 5'b11110, 4'b0110);
    apply(4'h9, 8'hFE, 8'h00, 1'b0); expect_out("R7", 8'h7F, 5'b11110, 4'b0000);
  endtask

  task automatic t_rotate;
    apply(4'hA, 8'h80, 8'h00, 1'b1); expect_out("R8", 8'h01, 5'b11110, 4'b0010);
    apply(4'hA, 8'h80, 8'h00, 1'b0); expect_out("R8", 8'h00, 5'b11110, 4'b0110);
    apply(4'hB, 8'h01, 8'h00, 1'b1); expect_out("R8", 8'h80, 5'b11110, 4'b1010);
    apply(4'hB, 8'h02, 8'h00, 1'b0); expect_out("R8", 8'h01, 5'b11110, 4'b0000);
  endtask

  task automatic t_bit;
    apply(4'hC, 8'h0F, 8'hC0, 1'b0); expect_out("R9", 8'h0F, 5'b01101, 4'b1101);
    apply(4'hC, 8'h41, 8'h41, 1'b1); expect_out("R9", 8'h41, 5'b01101, 4'b0001);
    apply(4'hC, 8'hFF, 8'h81, 1'b0); expect_out("R9", 8'hFF, 5'b01101, 4'b1000);
  endtask

  task automatic t_move;
    apply(4'hD, 8'h55, 8'h00, 1'b0); expect_out("R10", 8'h00, 5'b11100, 4'b0100);
    apply(4'hD, 8'h00, 8'h90, 1'b1); expect_out("R10", 8'h90, 5'b11100, 4'b1000);
    apply(4'hE, 8'h12, 8'h00, 1'b1); expect_out("R11", 8'h00, 5'b10000, 4'h0);
    apply(4'hE, 8'h12, 8'hFD, 1'b0); expect_out("R11", 8'hFD, 5'b10000, 4'h0);
    apply(4'hF, 8'hC3, 8'h00, 1'b0); expect_out("R12", 8'hC3, 5'b00000, 4'h0);
  endtask

  initial begin
    op = 4'hF; rv = 8'h00; mv = 8'h00; cy = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset; t_add; t_sub; t_logic; t_cmp; t_incdec; t_shift; t_rotate; t_bit; t_move;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule